// File: doc/BRIEF.md
# Decimating FIR Filter with Raw-Stream Bypass

This block filters a single stream of signed fixed-point samples with a fixed set of signed integer coefficients. It emits one filtered sample for every `RATE` samples it accepts. A sample is accepted in any cycle where `in_valid` is high. The coefficients are a parameter array. Each filtered sum is scaled down by `DROP_BITS` bit positions, rounded to the nearest integer with exact halves going toward zero, and clamped to the signed output range.

A run-time select, `active`, picks what appears on the output side. When it is low, the raw input stream passes straight through, with valid, enable and data taken from the inputs in the same cycle. When it is high, valid and data come from the filter and enable still follows the input. The filter keeps consuming samples in both settings. Switching the select therefore never leaves the sample history or the decimation phase stale.

Top module: `fir_dec_bypass`

## Requirements
- R1: A synchronous active-low reset clears the sample history to zero and the decimation phase to its first position. While reset is held, and until the first result, `out_valid` is 0 with `active` high.
- R2: With `active` high, `out_valid` is a single-cycle pulse. It rises in the clock cycle after every `RATE`-th accepted sample, counted from reset, and at no other time.
- R3: Cycles with `in_valid` low change neither the history nor the phase, and produce no output pulse.
- R4: The result for accepted sample n is the sum over k = 0..NTAPS-1 of COEFS[k]·x[n-k]. Here x[n] is the sample accepted in that cycle, and samples before reset count as zero.
- R5: The sum is divided by 2^DROP_BITS and rounded to the nearest integer, with an exact half rounded toward zero. With the defaults, a sum of 49152 gives 1 and a sum of -49152 gives -1.
- R6: A rounded value above 32767 is output as 32767, and one below -32768 is output as -32768.
- R7: With `active` low, `out_valid`, `out_enable` and `out_data` equal `in_valid`, `in_enable` and `in_data` in the same cycle.
- R8: With `active` high, `out_enable` equals `in_enable` in the same cycle, and `out_data` holds the last filtered result between pulses.
- R9: Samples accepted while `active` is low still enter the history and advance the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| active | input | 1 | 1 selects the filtered stream, 0 the raw stream |
| in_valid | input | 1 | Input sample qualifier |
| in_enable | input | 1 | Channel enable, forwarded unchanged |
| in_data | input | DATA_W | Signed input sample, 15 fractional bits |
| out_valid | output | 1 | Output sample qualifier |
| out_enable | output | 1 | Forwarded channel enable |
| out_data | output | DATA_W | Signed output sample |

## Verification
The properties assume that `RATE` is at least 2, so two filtered pulses can never be adjacent. They also assume that `active` changes only while no filtered result is in flight. A result that becomes due in the cycle the select drops is replaced by the raw stream. The stimulus respects this by going idle for one cycle, so any pending pulse is seen, before it flips `active`. It also drains the scoreboard before a mid-run reset. Everything else is free: valid gaps of any length, random enables, full-scale samples of both signs, and half-LSB sums.

// File: rtl/fir_dec_pkg.sv
`timescale 1ns/1ps
package fir_dec_pkg;

   // Accumulator width: full product plus growth for the tap count and a guard bit.
   function automatic int acc_width(input int data_w, input int coef_w, input int ntaps);
      return data_w + coef_w + $clog2(ntaps > 1 ? ntaps : 2) + 1;
   endfunction

   // Width of a phase counter that runs over 0..rate-1.
   function automatic int phase_width(input int rate);
      return (rate > 1) ? $clog2(rate) : 1;
   endfunction

endpackage

// File: rtl/fir_dec_taps.sv
`timescale 1ns/1ps
module fir_dec_taps #(
   parameter int DATA_W = 16,
   parameter int NTAPS  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     adv,
   input  logic signed [DATA_W-1:0] din,
   output logic signed [DATA_W-1:0] win [NTAPS]
);

   assign win[0] = din;

   if (NTAPS > 1) begin : g_line
      logic signed [DATA_W-1:0] hist [NTAPS-1];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int k = 0; k < NTAPS-1; k++) hist[k] <= '0;
         end else if (adv) begin
            hist[0] <= din;
            for (int k = 1; k < NTAPS-1; k++) hist[k] <= hist[k-1];
         end
      end

      for (genvar k = 1; k < NTAPS; k++) begin : g_win
         assign win[k] = hist[k-1];
      end
   end else begin : g_single
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst_n, adv};
   end

endmodule

// File: rtl/fir_dec_mac.sv
`timescale 1ns/1ps
module fir_dec_mac #(
   parameter int DATA_W = 16,
   parameter int COEF_W = 16,
   parameter int NTAPS  = 8,
   parameter int ACC_W  = 36,
   parameter logic signed [COEF_W-1:0] COEFS [NTAPS] = '{default: '0}
) (
   input  logic signed [DATA_W-1:0] win [NTAPS],
   output logic signed [ACC_W-1:0]  acc
);

   localparam int PW = DATA_W + COEF_W;

   logic signed [PW-1:0] prods [NTAPS];

   for (genvar k = 0; k < NTAPS; k++) begin : g_mul
      assign prods[k] = PW'(win[k]) * PW'(COEFS[k]);
   end

   always_comb begin
      acc = '0;
      for (int k = 0; k < NTAPS; k++) acc = acc + ACC_W'(prods[k]);
   end

endmodule

// File: rtl/fir_dec_quant.sv
`timescale 1ns/1ps
module fir_dec_quant #(
   parameter int ACC_W     = 36,
   parameter int DATA_W    = 16,
   parameter int DROP_BITS = 15
) (
   input  logic signed [ACC_W-1:0]  acc,
   output logic signed [DATA_W-1:0] q
);

   localparam int MW = ACC_W + 1;
   localparam logic [MW-1:0] HALF_M1 = (MW'(1) << (DROP_BITS-1)) - MW'(1);
   localparam logic [MW-1:0] LIM_P   = (MW'(1) << (DATA_W-1)) - MW'(1);
   localparam logic [MW-1:0] LIM_N   = MW'(1) << (DATA_W-1);

   logic                 neg;
   logic signed [MW-1:0] wide;
   logic [MW-1:0]        mag, rnd, nrnd;

   always_comb begin
      neg  = acc[ACC_W-1];
      wide = MW'(acc);
      mag  = neg ? unsigned'(-wide) : unsigned'(wide);
      rnd  = (mag + HALF_M1) >> DROP_BITS;
      nrnd = -rnd;
      if (!neg) q = (rnd > LIM_P) ? {1'b0, {(DATA_W-1){1'b1}}} : rnd[DATA_W-1:0];
      else      q = (rnd > LIM_N) ? {1'b1, {(DATA_W-1){1'b0}}} : nrnd[DATA_W-1:0];
   end

endmodule

// File: rtl/fir_dec_bypass.sv
`timescale 1ns/1ps
module fir_dec_bypass
   import fir_dec_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int COEF_W    = 16,
   parameter int NTAPS     = 8,
   parameter int RATE      = 4,
   parameter int DROP_BITS = 15,
   parameter logic signed [COEF_W-1:0] COEFS [NTAPS] =
      '{16'sd2048, -16'sd3072, 16'sd8192, 16'sd16384,
        16'sd16384, 16'sd8192, -16'sd3072, 16'sd2048}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              in_valid,
   input  logic              in_enable,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic              out_enable,
   output logic [DATA_W-1:0] out_data
);

   localparam int ACC_W = acc_width(DATA_W, COEF_W, NTAPS);
   localparam int PH_W  = phase_width(RATE);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(RATE - 1);

   if (RATE < 2)                    begin : g_bad_rate  $error("RATE must be at least 2");  end
   if (NTAPS < 1)                   begin : g_bad_taps  $error("NTAPS must be at least 1"); end
   if (DROP_BITS < 1)               begin : g_bad_drop  $error("DROP_BITS must be at least 1"); end
   if (ACC_W - DROP_BITS < DATA_W)  begin : g_bad_width $error("accumulator too narrow for output"); end

   logic signed [DATA_W-1:0] sample;
   logic signed [DATA_W-1:0] win [NTAPS];
   logic signed [ACC_W-1:0]  acc;
   logic signed [DATA_W-1:0] qdata;
   logic [PH_W-1:0]          phase;
   logic                     f_valid;
   logic [DATA_W-1:0]        f_data;

   assign sample = signed'(in_data);

   fir_dec_taps #(.DATA_W(DATA_W), .NTAPS(NTAPS)) u_taps (
      .clk(clk), .rst_n(rst_n), .adv(in_valid), .din(sample), .win(win)
   );

   fir_dec_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .NTAPS(NTAPS),
                 .ACC_W(ACC_W), .COEFS(COEFS)) u_mac (
      .win(win), .acc(acc)
   );

   fir_dec_quant #(.ACC_W(ACC_W), .DATA_W(DATA_W), .DROP_BITS(DROP_BITS)) u_quant (
      .acc(acc), .q(qdata)
   );

   // Decimation phase: advances on accepted samples only.
   always_ff @(posedge clk) begin
      if (!rst_n)        phase <= '0;
      else if (in_valid) phase <= (phase == PH_LAST) ? '0 : phase + PH_W'(1);
   end

   // Filtered result register: loads on the last sample of each group.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         f_valid <= 1'b0;
         f_data  <= '0;
      end else begin
         f_valid <= in_valid && (phase == PH_LAST);
         if (in_valid && (phase == PH_LAST)) f_data <= unsigned'(qdata);
      end
   end

   // Stream select: valid, enable and data switch together.
   always_comb begin
      out_enable = in_enable;
      if (active) begin
         out_valid = f_valid;
         out_data  = f_data;
      end else begin
         out_valid = in_valid;
         out_data  = in_data;
      end
   end

endmodule

// File: rtl/fir_dec_bypass_chk.sv
`timescale 1ns/1ps
module fir_dec_bypass_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              active,
   input logic              in_valid,
   input logic              in_enable,
   input logic [DATA_W-1:0] in_data,
   input logic              out_valid,
   input logic              out_enable,
   input logic [DATA_W-1:0] out_data,
   input logic              f_valid,
   input logic [DATA_W-1:0] f_data
);

   AST_RAW_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (out_valid == in_valid && out_enable == in_enable && out_data == in_data)); // R7

   AST_ENABLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (out_enable == in_enable)); // R8

   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      f_valid |=> !f_valid); // R2

   AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !f_valid); // R3

   AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !f_valid |-> $stable(f_data)); // R8

endmodule

bind fir_dec_bypass fir_dec_bypass_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .active(active), .in_valid(in_valid),
   .in_enable(in_enable), .in_data(in_data), .out_valid(out_valid),
   .out_enable(out_enable), .out_data(out_data), .f_valid(f_valid), .f_data(f_data)
);

// File: tb/fir_dec_bypass_tb.sv
`timescale 1ns/1ps
module fir_dec_bypass_tb;

   localparam int RATE  = 4;
   localparam int NTAPS = 8;
   localparam longint CF [NTAPS] = '{2048, -3072, 8192, 16384, 16384, 8192, -3072, 2048};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        active = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_enable = 1'b0;
   logic [15:0] in_data = '0;
   logic        out_valid, out_enable;
   logic [15:0] out_data;

   fir_dec_bypass u_dut (
      .clk(clk), .rst_n(rst_n), .active(active), .in_valid(in_valid),
      .in_enable(in_enable), .in_data(in_data), .out_valid(out_valid),
      .out_enable(out_enable), .out_data(out_data)
   );

   always #2.5 clk = ~clk;

   int          checks = 0, fails = 0;
   string       tag = "R1";
   longint      hist[$];
   int          acc_cnt = 0;
   logic [15:0] expq[$];
   int          n_exp = 0, n_got = 0;
   longint      cyc = 0, due = -1;
   bit          done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input bit ok, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Divide by 2^15, nearest with halves toward zero, then clamp.
   function automatic longint ref_round(input longint a);
      longint q, r;
      q = a / 32768;
      r = a % 32768;
      if (r < 0) r = -r;
      if (2 * r > 32768) q += (a < 0) ? -1 : 1;
      if (q > 32767)  q = 32767;
      if (q < -32768) q = -32768;
      return q;
   endfunction

   task automatic send(input bit v, input bit en, input logic [15:0] d);
      longint acc;
      @(posedge clk); #1;
      in_valid = v; in_enable = en; in_data = d;
      if (v) begin
         hist.push_front(longint'($signed(d)));
         if (hist.size() > NTAPS) void'(hist.pop_back());
         acc_cnt++;
         if (acc_cnt % RATE == 0 && active) begin
            acc = 0;
            for (int k = 0; k < NTAPS; k++)
               if (k < hist.size()) acc += CF[k] * hist[k];
            expq.push_back(16'(ref_round(acc)));
            n_exp++;
            due = cyc + 1;
         end
      end
      if (!active) begin
         #1;
         check("R7", out_valid == v && out_enable == en && out_data == d,
               {out_valid, out_enable, out_data}, {v, en, d});
      end
   endtask

   task automatic set_active(input bit a);
      @(posedge clk); #1 in_valid = 1'b0;
      @(posedge clk); #1 active = a;
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && active && !done) begin
         check("R2", out_valid == (cyc == due), out_valid, (cyc == due));
         if (out_valid) begin
            n_got++;
            check("R8", out_enable == in_enable, out_enable, in_enable);
            if (expq.size() == 0) check({tag, " unexpected"}, 1'b0, $signed(out_data), 0);
            else begin
               logic [15:0] e;
               e = expq.pop_front();
               check(tag, out_data == e, $signed(out_data), $signed(e));
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      check("R1", out_valid == 1'b0, out_valid, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1", out_valid == 1'b0, out_valid, 0);

      // R5: half-LSB sums; 3*16384 = 1.5 LSB -> 1, -3*16384 -> -1
      tag = "R5";
      send(1, 1, 16'd3);
      for (int i = 0; i < 7; i++) send(1, 1, 16'd0);
      send(1, 1, -16'sd3);
      for (int i = 0; i < 7; i++) send(1, 0, 16'd0);
      send(1, 1, 16'd11);
      for (int i = 0; i < 3; i++) send(1, 1, 16'd1);

      // R4: random full-range samples, back to back
      tag = "R4";
      for (int i = 0; i < 40; i++) send(1, 1'($urandom), 16'($urandom));

      // R3: idle cycles with junk data between samples
      tag = "R3";
      for (int i = 0; i < 60; i++) begin
         if ($urandom % 2) send(1, 1'($urandom), 16'($urandom));
         else              send(0, 1'($urandom), 16'($urandom));
      end

      // R6: saturation at both ends
      tag = "R6";
      for (int i = 0; i < 12; i++) send(1, 1, 16'h7FFF);
      for (int i = 0; i < 12; i++) send(1, 1, 16'h8000);

      // R7 / R9: bypass, filter keeps advancing with an odd sample count
      set_active(1'b0);
      tag = "R7";
      for (int i = 0; i < 9; i++) begin
         send(1, 1'($urandom), 16'($urandom));
         send(0, 1'($urandom), 16'($urandom));
      end
      set_active(1'b1);
      tag = "R9";
      for (int i = 0; i < 16; i++) send(1, 1, 16'($urandom));

      // R1: mid-run reset clears history and phase
      set_active(1'b1);
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      hist.delete();
      acc_cnt = 0;
      tag = "R1";
      send(1, 1, 16'd20000);
      for (int i = 0; i < 11; i++) send(1, 1, 16'd0);

      set_active(1'b1);
      repeat (3) @(posedge clk);
      #1 done = 1'b1;
      check("R2", expq.size() == 0, expq.size(), 0);
      check("R2", n_got == n_exp, n_got, n_exp);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule